// File: doc/BRIEF.md
# Memory Transaction Access Classifier

This block sits between the system bus and an external memory controller. For every request it accepts, it works out which region the address falls in: one of the SDRAM partitions, the flash/ROM space, or the configuration register space. It then picks one outcome for the request. The outcome is a normal command to the controller, a refresh-only cycle on all partitions, a silent drop, or a target abort. An abort is typed as a prefetch abort or a data abort.

A single access to a disabled partition is not treated as a fault. It becomes a refresh of every partition, which software uses while bringing the memory up. Whether a burst is legal depends on the region and, for flash, on the direction. The result appears as one-cycle strobes, registered one clock after the request handshake. While the downstream controller reports busy, the block accepts nothing.

Top module: `mem_access_classifier`

## Requirements
- R1: The top TAG_W address bits select the region. SDRAM_TAG (default 0xA) selects SDRAM, CFG_TAG (default 0x4) selects configuration space, and any other value selects flash/ROM. The bits above the PART_OFS_W-bit offset (default bits 27:26) give the partition. cmdRegion reports 0 for SDRAM, 1 for flash and 2 for configuration. cmdPart and cmdAddr report the partition and the address of the accepted request.
- R2: Any access to an SDRAM partition whose partEn bit is set gives a normal command (cmdStb). This covers single or burst, read or write, and any offset within the 64 MB partition. rdDataValid is raised together with cmdStb for reads only.
- R3: A single access to a disabled partition raises refreshReq alone, with no cmdStb and no rdDataValid, when its size equals the native unit. reqSize encodes 0 as byte, 1 as half-word and 2 as word. The native unit is a word when busHalf=0 and a half-word when busHalf=1.
- R4: A single access of any other size to a disabled partition is dropped silently: no strobe of any kind is raised.
- R5: Any burst, read or write, to a disabled partition raises abortStb.
- R6: In flash/ROM space a burst write aborts. Single reads, single writes and burst reads are normal commands.
- R7: In configuration space a burst aborts, a single access whose size is not a word aborts, and a single word access is a normal command.
- R8: abortPrefetch is 1 with abortStb when reqFetch was set, except for the non-word configuration abort of R7, which is always a data abort (abortPrefetch=0). abortPrefetch is never high without abortStb.
- R9: Each accepted request produces at most one of cmdStb, refreshReq and abortStb. The strobe is a single-cycle pulse in the cycle after the handshake. A dropped request produces none.
- R10: While ctrlBusy is high, reqReady is low, no request is sampled and no strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken this cycle |
| reqAddr | input | ADDR_W | Request byte address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBurst | input | 1 | 1 = burst, 0 = single beat |
| reqSize | input | 2 | 0 byte, 1 half-word, 2 word |
| reqFetch | input | 1 | Request comes from instruction fetch |
| partEn | input | NUM_PARTS | Per-partition enable mask |
| busHalf | input | 1 | 16-bit external data bus mode |
| ctrlBusy | input | 1 | Controller cannot take work |
| cmdStb | output | 1 | Normal command pulse |
| cmdAddr | output | ADDR_W | Address of the accepted request |
| cmdRegion | output | 2 | Region of the accepted request |
| cmdPart | output | PIDX_W | Partition of the accepted request |
| refreshReq | output | 1 | All-partition refresh pulse |
| abortStb | output | 1 | Target abort pulse |
| abortPrefetch | output | 1 | Abort is a prefetch abort |
| rdDataValid | output | 1 | Read data from this command is meaningful |

## Verification
The bench uses the default parameters: a 32-bit address, a 4-bit region tag, 26-bit partition offsets and four partitions. With these, partition indices 0 to 3 can be reached by fixed constants, and an address at the top of a partition shows that the unpopulated-offset case behaves like the base. A mask with two partitions enabled and two disabled puts both branches of every SDRAM rule within reach, in both bus width modes. The bench also covers flash and configuration addresses from both request sources, a busy stall, and back-to-back requests.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;

  typedef enum logic [1:0] {
    RGN_SDRAM = 2'd0,
    RGN_FLASH = 2'd1,
    RGN_CFG   = 2'd2
  } region_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // decode results handed from datapath to control
  typedef struct packed {
    region_e region;
    logic    partEnabled;
  } dec_s;

  // strobes from control to datapath
  typedef struct packed {
    logic fire;
    logic doCmd;
    logic doRefresh;
    logic doAbort;
    logic abortFetch;
    logic rdValid;
  } ctl_s;

endpackage

// File: rtl/mac_datapath.sv
`timescale 1ns/1ps
module mac_datapath
  import mac_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int TAG_W      = 4,
  parameter int PART_OFS_W = 26,
  parameter int NUM_PARTS  = 4,
  parameter logic [TAG_W-1:0] SDRAM_TAG = 4'hA,
  parameter logic [TAG_W-1:0] CFG_TAG   = 4'h4,
  localparam int PIDX_W = $clog2(NUM_PARTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [NUM_PARTS-1:0] partEn,
  input  ctl_s                 ctl,
  output dec_s                 dec,
  output logic                 cmdStb,
  output logic [ADDR_W-1:0]    cmdAddr,
  output logic [1:0]           cmdRegion,
  output logic [PIDX_W-1:0]    cmdPart,
  output logic                 refreshReq,
  output logic                 abortStb,
  output logic                 abortPrefetch,
  output logic                 rdDataValid
);

  logic [TAG_W-1:0]     tagField;
  logic [PIDX_W-1:0]    partIdx;
  logic [NUM_PARTS-1:0] partHit;

  assign tagField = reqAddr[ADDR_W-1 -: TAG_W];
  assign partIdx  = reqAddr[PART_OFS_W +: PIDX_W];

  // one hit line per partition; offset bits below PART_OFS_W never matter
  for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
    assign partHit[p] = (partIdx == PIDX_W'(p));
  end

  always_comb begin
    dec.partEnabled = |(partHit & partEn);
    if (tagField == SDRAM_TAG)    dec.region = RGN_SDRAM;
    else if (tagField == CFG_TAG) dec.region = RGN_CFG;
    else                          dec.region = RGN_FLASH;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdStb        <= 1'b0;
      refreshReq    <= 1'b0;
      abortStb      <= 1'b0;
      abortPrefetch <= 1'b0;
      rdDataValid   <= 1'b0;
      cmdAddr       <= '0;
      cmdRegion     <= 2'd0;
      cmdPart       <= '0;
    end else begin
      cmdStb        <= ctl.fire & ctl.doCmd;
      refreshReq    <= ctl.fire & ctl.doRefresh;
      abortStb      <= ctl.fire & ctl.doAbort;
      abortPrefetch <= ctl.fire & ctl.doAbort & ctl.abortFetch;
      rdDataValid   <= ctl.fire & ctl.rdValid;
      if (ctl.fire) begin
        cmdAddr   <= reqAddr;
        cmdRegion <= dec.region;
        cmdPart   <= partIdx;
      end
    end
  end

  // R9: never two outcomes in one cycle
  assert_single_outcome_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdStb, refreshReq, abortStb}));

  // R8: abort type only qualifies an abort
  assert_prefetch_qualified_R8: assert property (@(posedge clk) disable iff (!rstN)
    abortPrefetch |-> abortStb);

  // R2: read data qualifier only rides on a normal command
  assert_rdvalid_with_cmd_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdDataValid |-> cmdStb);

endmodule

// File: rtl/mac_control.sv
`timescale 1ns/1ps
module mac_control
  import mac_pkg::*;
(
  input  logic       reqValid,
  input  logic       ctrlBusy,
  input  logic       reqWrite,
  input  logic       reqBurst,
  input  logic [1:0] reqSize,
  input  logic       reqFetch,
  input  logic       busHalf,
  input  dec_s       dec,
  output logic       reqReady,
  output ctl_s       ctl
);

  logic nativeSize;

  assign reqReady   = !ctrlBusy;
  assign nativeSize = busHalf ? (reqSize == SZ_HALF) : (reqSize == SZ_WORD);

  // priority: abort, then refresh-only, then normal; drop when none applies
  always_comb begin
    ctl            = '0;
    ctl.fire       = reqValid & reqReady;
    unique case (dec.region)
      RGN_SDRAM: begin
        if (dec.partEnabled) begin
          ctl.doCmd = 1'b1;
        end else if (reqBurst) begin
          ctl.doAbort    = 1'b1;
          ctl.abortFetch = reqFetch;
        end else if (nativeSize) begin
          ctl.doRefresh = 1'b1;
        end
      end
      RGN_FLASH: begin
        if (reqBurst && reqWrite) begin
          ctl.doAbort    = 1'b1;
          ctl.abortFetch = reqFetch;
        end else begin
          ctl.doCmd = 1'b1;
        end
      end
      RGN_CFG: begin
        if (reqBurst) begin
          ctl.doAbort    = 1'b1;
          ctl.abortFetch = reqFetch;
        end else if (reqSize != SZ_WORD) begin
          ctl.doAbort    = 1'b1;
          ctl.abortFetch = 1'b0;
        end else begin
          ctl.doCmd = 1'b1;
        end
      end
      default: ctl.doCmd = 1'b0;
    endcase
    ctl.rdValid = ctl.doCmd & !reqWrite;
  end

endmodule

// File: rtl/mem_access_classifier.sv
`timescale 1ns/1ps
module mem_access_classifier
  import mac_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int TAG_W      = 4,
  parameter int PART_OFS_W = 26,
  parameter int NUM_PARTS  = 4,
  parameter logic [TAG_W-1:0] SDRAM_TAG = 4'hA,
  parameter logic [TAG_W-1:0] CFG_TAG   = 4'h4,
  localparam int PIDX_W = $clog2(NUM_PARTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 reqWrite,
  input  logic                 reqBurst,
  input  logic [1:0]           reqSize,
  input  logic                 reqFetch,
  input  logic [NUM_PARTS-1:0] partEn,
  input  logic                 busHalf,
  input  logic                 ctrlBusy,
  output logic                 cmdStb,
  output logic [ADDR_W-1:0]    cmdAddr,
  output logic [1:0]           cmdRegion,
  output logic [PIDX_W-1:0]    cmdPart,
  output logic                 refreshReq,
  output logic                 abortStb,
  output logic                 abortPrefetch,
  output logic                 rdDataValid
);

  dec_s dec;
  ctl_s ctl;

  mac_datapath #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .PART_OFS_W(PART_OFS_W),
    .NUM_PARTS(NUM_PARTS), .SDRAM_TAG(SDRAM_TAG), .CFG_TAG(CFG_TAG)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .partEn(partEn),
    .ctl(ctl), .dec(dec),
    .cmdStb(cmdStb), .cmdAddr(cmdAddr), .cmdRegion(cmdRegion),
    .cmdPart(cmdPart), .refreshReq(refreshReq), .abortStb(abortStb),
    .abortPrefetch(abortPrefetch), .rdDataValid(rdDataValid)
  );

  mac_control control_i (
    .reqValid(reqValid), .ctrlBusy(ctrlBusy), .reqWrite(reqWrite),
    .reqBurst(reqBurst), .reqSize(reqSize), .reqFetch(reqFetch),
    .busHalf(busHalf), .dec(dec), .reqReady(reqReady), .ctl(ctl)
  );

  // port-level views for the properties below
  logic              hs;
  logic              sdramHit;
  logic              cfgHit;
  logic              flashHit;
  logic              partOn;
  logic [PIDX_W-1:0] idxView;

  assign hs       = reqValid && reqReady;
  assign sdramHit = reqAddr[ADDR_W-1 -: TAG_W] == SDRAM_TAG;
  assign cfgHit   = reqAddr[ADDR_W-1 -: TAG_W] == CFG_TAG;
  assign flashHit = !sdramHit && !cfgHit;
  assign idxView  = reqAddr[PART_OFS_W +: PIDX_W];
  assign partOn   = partEn[idxView];

  assert_busy_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBusy |=> !(cmdStb || refreshReq || abortStb));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !hs |=> !(cmdStb || refreshReq || abortStb));

  assert_disabled_burst_abort_R5: assert property (@(posedge clk) disable iff (!rstN)
    hs && sdramHit && !partOn && reqBurst |=> abortStb);

  assert_enabled_cmd_R2: assert property (@(posedge clk) disable iff (!rstN)
    hs && sdramHit && partOn |=> cmdStb);

  assert_flash_burst_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    hs && flashHit && reqBurst && reqWrite |=> abortStb);

  assert_cfg_burst_abort_R7: assert property (@(posedge clk) disable iff (!rstN)
    hs && cfgHit && reqBurst |=> abortStb);

  assert_fetch_tag_R8: assert property (@(posedge clk) disable iff (!rstN)
    hs && reqBurst && cfgHit |=> (abortPrefetch == $past(reqFetch)));

  assert_refresh_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    hs && sdramHit && !partOn && !reqBurst &&
    (reqSize == (busHalf ? SZ_HALF : SZ_WORD)) |=> refreshReq && !cmdStb && !rdDataValid);

endmodule

// File: tb/mem_access_classifier_tb_top.sv
`timescale 1ns/1ps
module mem_access_classifier_tb_top;

  localparam int ADDR_W = 32;
  localparam int NPART  = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqBurst = 1'b0;
  logic [1:0]  reqSize = 2'd2;
  logic        reqFetch = 1'b0;
  logic [3:0]  partEn = 4'b0101;
  logic        busHalf = 1'b0;
  logic        ctrlBusy = 1'b0;
  logic        cmdStb;
  logic [31:0] cmdAddr;
  logic [1:0]  cmdRegion;
  logic [1:0]  cmdPart;
  logic        refreshReq;
  logic        abortStb;
  logic        abortPrefetch;
  logic        rdDataValid;

  always #2 clk = ~clk;  // 250 MHz

  mem_access_classifier dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqBurst(reqBurst),
    .reqSize(reqSize), .reqFetch(reqFetch), .partEn(partEn),
    .busHalf(busHalf), .ctrlBusy(ctrlBusy), .cmdStb(cmdStb),
    .cmdAddr(cmdAddr), .cmdRegion(cmdRegion), .cmdPart(cmdPart),
    .refreshReq(refreshReq), .abortStb(abortStb),
    .abortPrefetch(abortPrefetch), .rdDataValid(rdDataValid)
  );

  typedef struct {
    logic        cmd;
    logic        rfs;
    logic        abt;
    logic        pfa;
    logic        rdv;
    logic [1:0]  rgn;
    logic [1:0]  prt;
    logic [31:0] adr;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  // reference outcome, written from the requirement text
  function automatic exp_t model(logic [31:0] a, logic w, logic b, logic [1:0] sz,
                                 logic f, string tag);
    exp_t e;
    logic [1:0] native;
    e = '{cmd:0, rfs:0, abt:0, pfa:0, rdv:0, rgn:0, prt:0, adr:a, tag:tag};
    native = busHalf ? 2'd1 : 2'd2;
    e.prt = a[27:26];
    if (a[31:28] == 4'hA) begin
      e.rgn = 2'd0;
      if (partEn[a[27:26]]) e.cmd = 1;
      else if (b) begin e.abt = 1; e.pfa = f; end
      else if (sz == native) e.rfs = 1;
    end else if (a[31:28] == 4'h4) begin
      e.rgn = 2'd2;
      if (b) begin e.abt = 1; e.pfa = f; end
      else if (sz != 2'd2) e.abt = 1;
      else e.cmd = 1;
    end else begin
      e.rgn = 2'd1;
      if (b && w) begin e.abt = 1; e.pfa = f; end
      else e.cmd = 1;
    end
    e.rdv = e.cmd & !w;
    return e;
  endfunction

  task automatic send(logic [31:0] a, logic w, logic b, logic [1:0] sz, logic f,
                      string tag);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWrite = w; reqBurst = b;
    reqSize = sz; reqFetch = f;
    while (!reqReady) @(negedge clk);
    expQ.push_back(model(a, w, b, sz, f, tag));
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic checkBit(string tag, logic act, logic expv, string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, expv);
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN && !done) begin
        if (expQ.size() != 0) begin
          exp_t e;
          logic ok;
          e = expQ.pop_front();
          ok = (cmdStb === e.cmd) && (refreshReq === e.rfs) && (abortStb === e.abt) &&
               (abortPrefetch === e.pfa) && (rdDataValid === e.rdv);
          if (e.cmd)
            ok = ok && (cmdRegion === e.rgn) && (cmdPart === e.prt) && (cmdAddr === e.adr);
          checks++;
          if (!ok) begin
            fails++;
            $display("FAIL %s actual cmd=%0b rfs=%0b abt=%0b pfa=%0b rdv=%0b rgn=%0d prt=%0d adr=%h expected cmd=%0b rfs=%0b abt=%0b pfa=%0b rdv=%0b rgn=%0d prt=%0d adr=%h",
                     e.tag, cmdStb, refreshReq, abortStb, abortPrefetch, rdDataValid,
                     cmdRegion, cmdPart, cmdAddr, e.cmd, e.rfs, e.abt, e.pfa, e.rdv,
                     e.rgn, e.prt, e.adr);
          end
        end else if (cmdStb || refreshReq || abortStb) begin
          checks++;
          fails++;
          $display("FAIL R9 stray strobe actual cmd=%0b rfs=%0b abt=%0b expected none",
                   cmdStb, refreshReq, abortStb);
        end
      end
    end
  end

  // watchdog
  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    checkBit("R9 reset", cmdStb | refreshReq | abortStb | rdDataValid, 1'b0, "strobes");
    checkBit("R10 reset", reqReady, 1'b1, "reqReady");

    // R1 R2: enabled partitions, base and top offset
    send(32'hA000_0010, 0, 0, 2'd2, 0, "R2 part0 single read");
    send(32'hABFF_FFFC, 1, 1, 2'd2, 0, "R1 part2 top-offset burst write");
    send(32'hA800_0000, 0, 1, 2'd2, 1, "R2 part2 burst read");

    // R3 R4: disabled single accesses
    send(32'hA400_0000, 0, 0, 2'd2, 0, "R3 word read disabled part1");
    send(32'hAC00_0100, 1, 0, 2'd1, 0, "R4 half write disabled part3 bus32 drop");
    send(32'hA400_0003, 0, 0, 2'd0, 0, "R4 byte read disabled part1 drop");
    busHalf = 1'b1;
    send(32'hAC00_0002, 1, 0, 2'd1, 0, "R3 half write disabled part3 bus16");
    send(32'hA400_0000, 0, 0, 2'd2, 0, "R4 word read disabled bus16 drop");
    busHalf = 1'b0;

    // R5 R8: disabled bursts
    send(32'hA400_0040, 0, 1, 2'd2, 1, "R5 R8 burst read disabled fetch");
    send(32'hAFFF_FFF0, 1, 1, 2'd2, 0, "R5 burst write disabled data");

    // R6: flash space
    send(32'h0000_1000, 1, 0, 2'd1, 0, "R6 flash single write");
    send(32'h0000_2000, 0, 1, 2'd2, 1, "R6 flash burst read");
    send(32'h1000_0000, 1, 1, 2'd2, 0, "R6 flash burst write abort");
    send(32'h0000_3000, 1, 1, 2'd2, 1, "R6 R8 flash burst write fetch");

    // R7 R8: configuration space
    send(32'h4800_0004, 0, 0, 2'd2, 0, "R7 cfg word read");
    send(32'h4800_0010, 1, 0, 2'd1, 1, "R7 R8 cfg half write data abort");
    send(32'h4800_0000, 0, 1, 2'd2, 1, "R7 R8 cfg burst fetch");
    send(32'h4800_0008, 1, 1, 2'd2, 0, "R7 cfg burst write data");

    // R10: busy stall
    @(negedge clk);
    ctrlBusy = 1'b1;
    reqValid = 1'b1; reqAddr = 32'h4800_0024; reqWrite = 0; reqBurst = 0;
    reqSize = 2'd2; reqFetch = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checkBit("R10 busy", reqReady, 1'b0, "reqReady");
    end
    reqValid = 1'b0;
    @(negedge clk);
    ctrlBusy = 1'b0;
    send(32'h4800_0024, 0, 0, 2'd2, 0, "R10 after busy");

    // R9: back-to-back then idle
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 32'hA000_0000; reqWrite = 1; reqBurst = 0;
    reqSize = 2'd2; reqFetch = 0;
    expQ.push_back(model(32'hA000_0000, 1, 0, 2'd2, 0, "R9 b2b cmd"));
    @(negedge clk);
    reqAddr = 32'hA400_0000;
    expQ.push_back(model(32'hA400_0000, 1, 0, 2'd2, 0, "R9 b2b refresh"));
    @(negedge clk);
    reqAddr = 32'h4800_0000; reqBurst = 1;
    expQ.push_back(model(32'h4800_0000, 1, 1, 2'd2, 0, "R9 b2b abort"));
    @(negedge clk);
    reqValid = 1'b0; reqBurst = 0;
    repeat (4) @(negedge clk);
    checkBit("R9 idle", cmdStb | refreshReq | abortStb, 1'b0, "strobes");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule